// File: doc/BRIEF.md
# Transactional Cache Overflow Tracker

This block keeps the tags and per-line state of a two-way set-associative cache used by a hardware transactional memory. Every line carries a transactional mark that is set when a transaction touches it. Each set carries a spill flag. When a miss has to evict a marked line, the line's full address goes into a small associative spill buffer instead of ending the transaction. The set's spill flag is then raised, so that later misses in that set search the buffer. If the buffer holds the wanted address, that line trades places with the chosen victim.

Two cleanup paths are provided. Abort is a single cycle. It drops every marked line from the cache, empties the spill buffer and clears all marks and flags. The pre-transaction values are assumed to live below this cache. Commit is a fixed-length walk over the spill buffer. It emits one write-back slot per cycle and then clears all marks and flags, leaving the lines resident. While the walk runs, the block reports busy, refuses new work and refuses snooping requests from other agents. The data payload and the memory below are outside the block; only addresses leave it.

Top module: `tco_tracker`

## Requirements
- R1: After synchronous reset every line is invalid, every spill flag and mark is clear, the spill buffer is empty, and all outputs are low.
- R2: A request is answered one cycle later on `resp_valid`, with exactly one of hit, buffer hit, spill or spill-failure set, or none of them for a plain miss. The set index is the low `SET_W` address bits and the tag is the rest.
- R3: A request with `req_txn` high sets the mark of the line it hits or installs. A request with `req_txn` low leaves existing marks unchanged and installs unmarked lines.
- R4: On a miss the victim is an invalid way, taking way 0 before way 1. When both ways are valid, the victim is the least recently used way, and every hit or install makes the other way the next victim.
- R5: A miss whose victim is a valid marked line writes the victim's address into the lowest free buffer slot, sets the set's spill flag and reports `resp_spill`. An unmarked victim is dropped without a spill.
- R6: A miss in a set with its spill flag set whose address is in the buffer reports `resp_ovf_hit`. It installs the line as marked in the victim way. The victim takes over the buffer slot if it is marked; otherwise the slot is freed.
- R7: A spill that finds no free slot reports `ovf_abort`, drops the request and performs the abort cleanup of R8 in the same cycle.
- R8: Abort invalidates every marked line, empties the buffer and clears all marks and spill flags. Unmarked lines stay valid.
- R9: Commit raises `busy` for exactly `OVF_DEPTH` cycles. It visits buffer slots in ascending index, one per cycle, and pulses `wb_valid` with `wb_addr` for each occupied slot. Afterwards all marks and flags are clear, the buffer is empty and the lines remain valid.
- R10: While `busy` is high, requests, abort and commit are ignored.
- R11: `snoop_nack` is high in the cycle after `snoop_valid` if `busy` was high, and low otherwise.
- R12: Without `busy`, abort takes precedence over commit, and commit over a request, when they arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Line address: tag above set index |
| req_txn | input | 1 | Access belongs to the running transaction |
| abort_req | input | 1 | Start abort cleanup |
| commit_req | input | 1 | Start commit walk |
| snoop_valid | input | 1 | External intervention arriving |
| resp_valid | output | 1 | Request answered |
| resp_hit | output | 1 | Cache hit |
| resp_ovf_hit | output | 1 | Found in spill buffer and swapped in |
| resp_spill | output | 1 | Marked victim moved to spill buffer |
| ovf_abort | output | 1 | Spill buffer full, transaction aborted |
| busy | output | 1 | Commit walk in progress |
| snoop_nack | output | 1 | Intervention refused |
| wb_valid | output | 1 | Spilled line written back this cycle |
| wb_addr | output | ADDR_W | Address of written-back line |

## Verification
Two pairs of functions can land in one cycle. The first pair is a control command and a request: abort, commit and an access are raised on the same edge. The outputs and later hits show which one acted, with abort ahead of commit ahead of the access. The second pair is a spill and the abort it forces: one set is driven through enough marked misses to fill the buffer, and the next spill must report `ovf_abort` instead of `resp_spill`. After that spill, resident marked lines miss, formerly spilled addresses miss without a buffer hit, and a commit walk writes back nothing.

// File: rtl/tco_pkg.sv
package tco_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_WALK,
    ACT_ABORT,
    ACT_COMMIT,
    ACT_HIT,
    ACT_SWAP,
    ACT_FILL,
    ACT_OVFAB
  } tco_act_e;
endpackage

// File: rtl/tco_way_match.sv
module tco_way_match #(
  parameter int WAYS  = 2,
  parameter int TAG_W = 6
) (
  input  logic [WAYS-1:0]            vld,
  input  logic [WAYS-1:0][TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]           probe,
  output logic [WAYS-1:0]            hit
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit[w] = vld[w] && (tags[w] == probe);
  end
endmodule

// File: rtl/tco_ovf_store.sv
module tco_ovf_store #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 4,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] srch_addr,
  output logic              srch_hit,
  output logic [IDX_W-1:0]  srch_idx,
  output logic              free_ok,
  output logic [IDX_W-1:0]  free_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  input  logic              flush,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [ADDR_W-1:0] rd_addr
);
  logic [DEPTH-1:0]  ent_vld;
  logic [ADDR_W-1:0] ent_addr [DEPTH];

  // lowest matching slot and lowest free slot
  always_comb begin
    srch_hit = 1'b0;
    srch_idx = '0;
    free_ok  = 1'b0;
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (ent_vld[i] && ent_addr[i] == srch_addr) begin
        srch_hit = 1'b1;
        srch_idx = IDX_W'(i);
      end
      if (!ent_vld[i]) begin
        free_ok  = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      ent_vld <= '0;
    end else begin
      if (clr_en) ent_vld[clr_idx] <= 1'b0;
      if (wr_en)  ent_vld[wr_idx]  <= 1'b1;
    end
  end

  // address array carries no reset
  always_ff @(posedge clk) begin
    if (wr_en) ent_addr[wr_idx] <= wr_addr;
  end

  assign rd_valid = ent_vld[rd_idx];
  assign rd_addr  = ent_addr[rd_idx];
endmodule

// File: rtl/tco_tracker.sv
module tco_tracker
  import tco_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int SET_W     = 2,
  parameter int OVF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_txn,
  input  logic              abort_req,
  input  logic              commit_req,
  input  logic              snoop_valid,
  output logic              resp_valid,
  output logic              resp_hit,
  output logic              resp_ovf_hit,
  output logic              resp_spill,
  output logic              ovf_abort,
  output logic              busy,
  output logic              snoop_nack,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr
);
  localparam int NSETS = 1 << SET_W;
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAYS  = 2;
  localparam int IDX_W = (OVF_DEPTH > 1) ? $clog2(OVF_DEPTH) : 1;
  localparam logic [IDX_W-1:0] LAST = IDX_W'(OVF_DEPTH - 1);

  logic [WAYS-1:0]            vld_q [NSETS];
  logic [WAYS-1:0]            tb_q  [NSETS];
  logic [WAYS-1:0][TAG_W-1:0] tag_q [NSETS];
  logic [NSETS-1:0]           ob_q, lru_q;
  logic [IDX_W-1:0]           ptr_q;

  logic [SET_W-1:0]  set_i;
  logic [TAG_W-1:0]  tag_i;
  logic [WAYS-1:0]   hitv;
  logic              hit_way, vic_way, vic_t;
  logic [ADDR_W-1:0] vic_addr;
  logic              srch_hit, free_ok, rd_valid;
  logic [IDX_W-1:0]  srch_idx, free_idx;
  logic [ADDR_W-1:0] rd_addr;
  logic              st_wr, st_clr, st_flush;
  logic [IDX_W-1:0]  st_wr_idx, st_clr_idx;
  tco_act_e          act;

  assign set_i = req_addr[SET_W-1:0];
  assign tag_i = req_addr[ADDR_W-1:SET_W];

  tco_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) match_i (
    .vld(vld_q[set_i]), .tags(tag_q[set_i]), .probe(tag_i), .hit(hitv)
  );

  assign hit_way = hitv[1];

  always_comb begin
    if (!vld_q[set_i][0])      vic_way = 1'b0;
    else if (!vld_q[set_i][1]) vic_way = 1'b1;
    else                       vic_way = lru_q[set_i];
  end

  assign vic_t    = vld_q[set_i][vic_way] && tb_q[set_i][vic_way];
  assign vic_addr = {tag_q[set_i][vic_way], set_i};

  tco_ovf_store #(.ADDR_W(ADDR_W), .DEPTH(OVF_DEPTH)) store_i (
    .clk(clk), .rst(rst),
    .srch_addr(req_addr), .srch_hit(srch_hit), .srch_idx(srch_idx),
    .free_ok(free_ok), .free_idx(free_idx),
    .wr_en(st_wr), .wr_idx(st_wr_idx), .wr_addr(vic_addr),
    .clr_en(st_clr), .clr_idx(st_clr_idx), .flush(st_flush),
    .rd_idx(ptr_q), .rd_valid(rd_valid), .rd_addr(rd_addr)
  );

  // one action per cycle, in priority order
  always_comb begin
    if (busy)                               act = ACT_WALK;
    else if (abort_req)                     act = ACT_ABORT;
    else if (commit_req)                    act = ACT_COMMIT;
    else if (!req_valid)                    act = ACT_IDLE;
    else if (|hitv)                         act = ACT_HIT;
    else if (ob_q[set_i] && srch_hit)       act = ACT_SWAP;
    else if (vic_t && !free_ok)             act = ACT_OVFAB;
    else                                    act = ACT_FILL;
  end

  always_comb begin
    st_wr      = vic_t && (act == ACT_SWAP || act == ACT_FILL);
    st_wr_idx  = (act == ACT_SWAP) ? srch_idx : free_idx;
    st_clr     = (act == ACT_WALK) || (act == ACT_SWAP && !vic_t);
    st_clr_idx = (act == ACT_WALK) ? ptr_q : srch_idx;
    st_flush   = (act == ACT_ABORT) || (act == ACT_OVFAB) ||
                 (act == ACT_WALK && ptr_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSETS; s++) begin
        vld_q[s] <= '0;
        tb_q[s]  <= '0;
        tag_q[s] <= '0;
      end
      ob_q  <= '0;
      lru_q <= '0;
      ptr_q <= '0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_ovf_hit <= 1'b0;
      resp_spill <= 1'b0; ovf_abort <= 1'b0; busy <= 1'b0;
      snoop_nack <= 1'b0; wb_valid <= 1'b0; wb_addr <= '0;
    end else begin
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_ovf_hit <= 1'b0;
      resp_spill <= 1'b0; ovf_abort <= 1'b0; wb_valid <= 1'b0;
      snoop_nack <= snoop_valid && busy;
      case (act)
        ACT_WALK: begin
          wb_valid <= rd_valid;
          wb_addr  <= rd_addr;
          ptr_q    <= ptr_q + 1'b1;
          if (ptr_q == LAST) begin
            busy <= 1'b0;
            ob_q <= '0;
            for (int s = 0; s < NSETS; s++) tb_q[s] <= '0;
          end
        end
        ACT_ABORT, ACT_OVFAB: begin
          for (int s = 0; s < NSETS; s++) begin
            vld_q[s] <= vld_q[s] & ~tb_q[s];
            tb_q[s]  <= '0;
          end
          ob_q <= '0;
          if (act == ACT_OVFAB) begin
            resp_valid <= 1'b1;
            ovf_abort  <= 1'b1;
          end
        end
        ACT_COMMIT: begin
          busy  <= 1'b1;
          ptr_q <= '0;
        end
        ACT_HIT: begin
          resp_valid <= 1'b1;
          resp_hit   <= 1'b1;
          if (req_txn) tb_q[set_i][hit_way] <= 1'b1;
          lru_q[set_i] <= ~hit_way;
        end
        ACT_SWAP: begin
          resp_valid   <= 1'b1;
          resp_ovf_hit <= 1'b1;
          vld_q[set_i][vic_way] <= 1'b1;
          tag_q[set_i][vic_way] <= tag_i;
          tb_q[set_i][vic_way]  <= 1'b1;
          lru_q[set_i]          <= ~vic_way;
        end
        ACT_FILL: begin
          resp_valid <= 1'b1;
          vld_q[set_i][vic_way] <= 1'b1;
          tag_q[set_i][vic_way] <= tag_i;
          tb_q[set_i][vic_way]  <= req_txn;
          lru_q[set_i]          <= ~vic_way;
          if (vic_t) begin
            resp_spill  <= 1'b1;
            ob_q[set_i] <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tco_tracker_chk.sv
module tco_tracker_chk #(
  parameter int OVF_DEPTH = 4
) (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic abort_req,
  input logic snoop_valid,
  input logic resp_valid,
  input logic resp_hit,
  input logic resp_ovf_hit,
  input logic resp_spill,
  input logic ovf_abort,
  input logic busy,
  input logic snoop_nack,
  input logic wb_valid
);
  int unsigned run_q;

  always_ff @(posedge clk) begin
    if (rst)       run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_RESP_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> ($past(req_valid) && !$past(busy))); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    $onehot0({resp_hit, resp_ovf_hit, resp_spill, ovf_abort})); // R2
  AST_OUTCOME_HAS_RESP: assert property (@(posedge clk) disable iff (rst)
    (resp_hit || resp_ovf_hit || resp_spill || ovf_abort) |-> resp_valid); // R5
  AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (rst)
    busy |=> !resp_valid); // R10
  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && busy) |=> snoop_nack); // R11
  AST_NO_IDLE_NACK: assert property (@(posedge clk) disable iff (rst)
    (snoop_valid && !busy) |=> !snoop_nack); // R11
  AST_WB_IN_WALK: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> $past(busy)); // R9
  AST_WALK_LEN: assert property (@(posedge clk) disable iff (rst)
    busy |-> (run_q < OVF_DEPTH)); // R9
  AST_ABORT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (abort_req && !busy) |=> (!busy && !resp_valid)); // R12
endmodule

bind tco_tracker tco_tracker_chk #(.OVF_DEPTH(OVF_DEPTH)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid), .abort_req(abort_req),
  .snoop_valid(snoop_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
  .resp_ovf_hit(resp_ovf_hit), .resp_spill(resp_spill), .ovf_abort(ovf_abort),
  .busy(busy), .snoop_nack(snoop_nack), .wb_valid(wb_valid)
);

// File: tb/tco_tracker_tb.sv
module tco_tracker_tb_top;
  localparam int AW = 8;
  localparam int SW = 2;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_txn = 1'b0, abort_req = 1'b0;
  logic commit_req = 1'b0, snoop_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic resp_valid, resp_hit, resp_ovf_hit, resp_spill, ovf_abort;
  logic busy, snoop_nack, wb_valid;
  logic [AW-1:0] wb_addr;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5ns clk = ~clk;

  tco_tracker #(.ADDR_W(AW), .SET_W(SW), .OVF_DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_txn(req_txn), .abort_req(abort_req), .commit_req(commit_req),
    .snoop_valid(snoop_valid), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_ovf_hit(resp_ovf_hit), .resp_spill(resp_spill), .ovf_abort(ovf_abort),
    .busy(busy), .snoop_nack(snoop_nack), .wb_valid(wb_valid), .wb_addr(wb_addr)
  );

  function automatic logic [AW-1:0] mk(input int t, input int s);
    return AW'((t << SW) | s);
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  // exp = {hit, ovf_hit, spill, ovf_abort}
  task automatic acc(input int t, input int s, input logic txn,
                     input logic [3:0] exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_addr = mk(t, s); req_txn = txn;
    @(negedge clk);
    req_valid = 1'b0; req_txn = 1'b0;
    chk(req, "response", {27'd0, resp_valid, resp_hit, resp_ovf_hit, resp_spill, ovf_abort},
        {27'd0, 1'b1, exp});
  endtask

  task automatic do_abort();
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    chk("R8", "abort busy/resp", {30'd0, busy, resp_valid}, 32'd0);
  endtask

  // commit walk with requests, abort and snoops held on throughout
  task automatic commit_walk(input logic [DEPTH-1:0] ev, input logic [AW-1:0] ea [DEPTH]);
    @(negedge clk); commit_req = 1'b1;
    @(negedge clk); commit_req = 1'b0;
    chk("R9", "busy after commit", {31'd0, busy}, 32'd1);
    req_valid = 1'b1; req_addr = '0; snoop_valid = 1'b1; abort_req = 1'b1;
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      chk("R9", "wb_valid", {31'd0, wb_valid}, {31'd0, ev[k]});
      if (ev[k]) chk("R9", "wb_addr", {24'd0, wb_addr}, {24'd0, ea[k]});
      chk("R9", "busy length", {31'd0, busy}, {31'd0, k != DEPTH - 1});
      chk("R10", "no resp while busy", {31'd0, resp_valid}, 32'd0);
      chk("R11", "nack while busy", {31'd0, snoop_nack}, 32'd1);
    end
    req_valid = 1'b0; snoop_valid = 1'b0; abort_req = 1'b0;
  endtask

  initial begin
    logic [AW-1:0] ea [DEPTH];
    do_reset();
    chk("R1", "outputs after reset",
        {23'd0, resp_valid, resp_hit, resp_ovf_hit, resp_spill, ovf_abort, busy, snoop_nack, wb_valid, 1'b0},
        32'd0);
    chk("R1", "wb_addr after reset", {24'd0, wb_addr}, 32'd0);

    // R4 / R2: LRU sweep over every set, unmarked
    for (int s = 0; s < (1 << SW); s++) begin
      acc(1, s, 0, 4'b0000, "R2");
      acc(2, s, 0, 4'b0000, "R4");
      acc(1, s, 0, 4'b1000, "R2");
      acc(3, s, 0, 4'b0000, "R4");   // evicts tag 2 unmarked, no spill (R5)
      acc(1, s, 0, 4'b1000, "R4");
      acc(2, s, 0, 4'b0000, "R4");   // evicts tag 3
      acc(2, s, 0, 4'b1000, "R2");
    end

    // R5 / R6 / R9 per set
    for (int s = 0; s < (1 << SW); s++) begin
      do_reset();
      acc(1, s, 1, 4'b0000, "R3");
      acc(2, s, 1, 4'b0000, "R3");
      acc(3, s, 1, 4'b0010, "R5");   // tag 1 spilled to slot 0
      acc(1, s, 1, 4'b0100, "R6");   // tag 2 takes slot 0
      acc(2, s, 1, 4'b0100, "R6");   // tag 3 takes slot 0
      ea[0] = mk(3, s); ea[1] = '0; ea[2] = '0; ea[3] = '0;
      commit_walk(4'b0001, ea);
      acc(2, s, 0, 4'b1000, "R9");
      acc(1, s, 0, 4'b1000, "R9");
      acc(4, s, 0, 4'b0000, "R9");   // marks cleared: no spill
      acc(2, s, 0, 4'b0000, "R9");   // flags cleared: no buffer hit
    end

    // R9 slot order with three spills
    do_reset();
    for (int t = 1; t <= 5; t++) acc(t, 2, 1, (t > 2) ? 4'b0010 : 4'b0000, "R5");
    ea[0] = mk(1, 2); ea[1] = mk(2, 2); ea[2] = mk(3, 2); ea[3] = '0;
    commit_walk(4'b0111, ea);

    // R7: fill the buffer then overflow
    do_reset();
    for (int t = 1; t <= 6; t++) acc(t, 0, 1, (t > 2) ? 4'b0010 : 4'b0000, "R5");
    acc(7, 0, 1, 4'b0001, "R7");
    acc(6, 0, 0, 4'b0000, "R7");     // resident marked line dropped
    acc(1, 0, 0, 4'b0000, "R7");     // buffer emptied
    for (int k = 0; k < DEPTH; k++) ea[k] = '0;
    commit_walk(4'b0000, ea);

    // R3 / R8: abort keeps unmarked lines
    do_reset();
    acc(1, 1, 0, 4'b0000, "R3");
    acc(2, 1, 1, 4'b0000, "R3");
    acc(2, 1, 0, 4'b1000, "R3");     // unmarked hit keeps the mark
    do_abort();
    acc(1, 1, 0, 4'b1000, "R8");
    acc(2, 1, 0, 4'b0000, "R8");
    acc(1, 1, 1, 4'b1000, "R3");     // marked by a transactional hit
    do_abort();
    acc(1, 1, 0, 4'b0000, "R3");

    // R8: abort empties the buffer
    do_reset();
    acc(1, 3, 1, 4'b0000, "R8");
    acc(2, 3, 1, 4'b0000, "R8");
    acc(3, 3, 1, 4'b0010, "R8");
    do_abort();
    acc(1, 3, 1, 4'b0000, "R8");

    // R11: idle snoop not refused
    @(negedge clk); snoop_valid = 1'b1;
    @(negedge clk); snoop_valid = 1'b0;
    chk("R11", "idle nack", {31'd0, snoop_nack}, 32'd0);

    // R12: abort beats commit beats request
    do_reset();
    acc(1, 0, 1, 4'b0000, "R12");
    @(negedge clk);
    abort_req = 1'b1; commit_req = 1'b1; req_valid = 1'b1; req_addr = mk(1, 0); req_txn = 1'b1;
    @(negedge clk);
    abort_req = 1'b0; commit_req = 1'b0; req_valid = 1'b0; req_txn = 1'b0;
    chk("R12", "abort wins busy/resp", {30'd0, busy, resp_valid}, 32'd0);
    acc(1, 0, 1, 4'b0000, "R12");    // line was dropped by abort
    @(negedge clk);
    commit_req = 1'b1; req_valid = 1'b1; req_addr = mk(5, 0);
    @(negedge clk);
    commit_req = 1'b0; req_valid = 1'b0;
    chk("R12", "commit wins busy/resp", {30'd0, busy, resp_valid}, 32'd2);
    repeat (DEPTH) @(negedge clk);
    chk("R12", "walk finished", {31'd0, busy}, 32'd0);
    acc(1, 0, 0, 4'b1000, "R12");
    acc(5, 0, 0, 4'b0000, "R12");    // request under commit was dropped

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      vectors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule